// File: doc/BRIEF.md
# DMA Dispatcher Control and Status Register Block

This block is the software-facing register file of a descriptor-driven DMA dispatcher. A 32-bit memory-mapped slave port lets software read engine status, program run-control policy, read FIFO fill levels and, when the option is built in, read the sequence numbers of the read and write engines. The dispatcher feeds in its busy flag, the empty and full flags of its descriptor and response buffers, fill levels, sequence numbers and single-cycle error, early-termination and transfer-complete events.

The block drives three signals back into the engine. The first tells the dispatcher to stop issuing commands. The second is a fixed-length software reset pulse. The third is the interrupt line. It also applies the auto-stop policy: when an error or early-termination event arrives and the matching stop-on policy bit is enabled, hardware sets the stop bit itself. A pending interrupt is cleared only by writing a 1 to it. A software reset clears all engine state. During that reset, control writes are ignored.

Top module: `dma_csr_regs`

## Requirements
- R1: After the synchronous reset, the control register reads 0, and irq, halt_issue and sw_rst_pulse are low.
- R2: A read whose strobe is seen at a clock edge returns its data on bus_rdata from that edge on. bus_rdata holds its value until the next read. Byte offset 0x8 returns the write fill level in bits 31:16 and the read fill level in bits 15:0. Offset 0xC returns the response fill level in bits 15:0. Offset 0x10 returns the write sequence number in bits 31:16 and the read sequence number in bits 15:0.
- R3: Offsets 0x14 to 0x1C read as 0. Offset 0x10 reads as 0 when SEQ_EN is 0.
- R4: Status (offset 0x0) bit 0 is busy, bit 1 is descriptor buffer empty, bit 2 is descriptor buffer full, bit 3 is response buffer empty and bit 4 is response buffer full, each taken from its input. Bits 31:10 read 0.
- R5: Control (offset 0x4) stores bits 0 (stop), 2 (stop on error), 3 (stop on early termination), 4 (interrupt enable) and 5 (halt issue). Bits 1 and 31:6 read 0. halt_issue is high exactly while bit 5 is set.
- R6: Writes to status bits other than bit 9 have no effect. Writes to offsets 0x8, 0xC, 0x10 and above change nothing.
- R7: Status bit 9 (interrupt pending) is set by a transfer-complete or error event. It is cleared only by writing a 1 to status bit 9. If a set and a clear arrive in the same cycle, the set wins.
- R8: irq equals status bit 9 ANDed with control bit 4.
- R9: An error event while control bit 2 is set sets control bit 0 and status bit 7 (stopped on error). With bit 2 clear, neither is set.
- R10: An early-termination event while control bit 3 is set sets control bit 0 and status bit 8 (stopped on early termination). With bit 3 clear, neither is set. Early termination does not set status bit 9.
- R11: Status bit 5 (stop state) reads 1 exactly when control bit 0 is set and busy is low.
- R12: Writing 1 to control bit 1 clears the control register, status bits 7, 8 and 9 and the interrupt. It raises sw_rst_pulse for RST_CYCLES cycles (default 4). Status bit 6 reads 1 during that window, and control writes and events in the window are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 5 | Byte offset of the access (bits 4:2 select the word) |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| eng_busy | input | 1 | Engine busy |
| desc_empty | input | 1 | Descriptor buffer empty |
| desc_full | input | 1 | Descriptor buffer full |
| resp_empty | input | 1 | Response buffer empty |
| resp_full | input | 1 | Response buffer full |
| wr_fill | input | 16 | Write descriptor fill level |
| rd_fill | input | 16 | Read descriptor fill level |
| resp_fill | input | 16 | Response fill level |
| wr_seq | input | 16 | Write sequence number |
| rd_seq | input | 16 | Read sequence number |
| ev_error | input | 1 | Single-cycle error event |
| ev_early | input | 1 | Single-cycle early-termination event |
| ev_done | input | 1 | Single-cycle transfer-complete event |
| halt_issue | output | 1 | Stop issuing read/write commands |
| sw_rst_pulse | output | 1 | Software reset to the rest of the engine |
| irq | output | 1 | Interrupt request |

## Verification
A wrong control or pending-interrupt state shows up on halt_issue and irq on the very next cycle. It also shows one cycle after a read of offset 0x4 or 0x0, so each scenario reads back immediately after its stimulus. A wrong reset counter changes the count of high cycles on sw_rst_pulse and the value of status bit 6 mid-window, and the bench measures both. The auto-stop and clear paths are tried with the policy bits both on and off, and with a set and a clear landing in the same cycle. That way a policy bit that is ignored, or a priority that is inverted, changes a read value.

// File: rtl/dcsr_pkg.sv
// Shared word indices and bit positions of the DMA control/status register file.
// Assumes word-aligned accesses; the word index is byte offset bits 4:2.
package dcsr_pkg;
    typedef enum logic [2:0] {
        W_STATUS  = 3'd0,
        W_CONTROL = 3'd1,
        W_DFILL   = 3'd2,
        W_RFILL   = 3'd3,
        W_SEQ     = 3'd4
    } word_e;

    localparam int CTL_W        = 6;
    localparam int CB_STOP      = 0;
    localparam int CB_SWRST     = 1;
    localparam int CB_STOP_ERR  = 2;
    localparam int CB_STOP_EARL = 3;
    localparam int CB_IRQ_EN    = 4;
    localparam int CB_HALT      = 5;

    localparam int SB_IRQ       = 9;
    localparam int STAT_W       = 10;
endpackage

// File: rtl/dcsr_reset_seq.sv
// Software reset sequencer: on a start strobe, holds active high for RST_CYCLES
// clock cycles. A start while already active is not expected (the caller masks it).
module dcsr_reset_seq #(
    parameter int RST_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic active
);
    localparam int CW = $clog2(RST_CYCLES + 1);

    logic [CW-1:0] cnt_q;

    // Load the window length on start, count down to zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (start)
            cnt_q <= CW'(RST_CYCLES);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign active = (cnt_q != '0);
endmodule

// File: rtl/dcsr_control.sv
// Control register with hardware auto-stop and sticky stopped-on flags.
// Assumes wr_en is already masked during a software reset window and that clr
// covers both the start cycle and the window itself.
module dcsr_control
    import dcsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [CTL_W-1:0]  wdata,
    input  logic              ev_error,
    input  logic              ev_early,
    output logic [CTL_W-1:0]  ctl_q,
    output logic              stop_err_q,
    output logic              stop_early_q
);
    logic              hit_err;
    logic              hit_early;
    logic [CTL_W-1:0]  ctl_d;

    assign hit_err   = ev_error && ctl_q[CB_STOP_ERR];
    assign hit_early = ev_early && ctl_q[CB_STOP_EARL];

    // Next control value: software write first, hardware stop ORed on top.
    always_comb begin
        ctl_d = ctl_q;
        if (wr_en) begin
            ctl_d           = wdata;
            ctl_d[CB_SWRST] = 1'b0;
        end
        if (hit_err || hit_early)
            ctl_d[CB_STOP] = 1'b1;
    end

    // Control register storage.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            ctl_q <= '0;
        else
            ctl_q <= ctl_d;
    end

    // Sticky stopped-on-error / stopped-on-early-termination flags.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            stop_err_q   <= 1'b0;
            stop_early_q <= 1'b0;
        end else begin
            if (hit_err)
                stop_err_q <= 1'b1;
            if (hit_early)
                stop_early_q <= 1'b1;
        end
    end
endmodule

// File: rtl/dcsr_irq.sv
// Interrupt pending flag: set by completion or error, cleared by a write of 1.
// A set in the same cycle as a clear wins; clr (software reset) beats both.
module dcsr_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic set_ev,
    input  logic w1c,
    output logic pend_q
);
    // Pending flag update with set-over-clear priority.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            pend_q <= 1'b0;
        else if (set_ev)
            pend_q <= 1'b1;
        else if (w1c)
            pend_q <= 1'b0;
    end
endmodule

// File: rtl/dcsr_readback.sv
// Registered read multiplexer. Samples the selected word on a read strobe and
// holds it otherwise. SEQ_EN selects whether the sequence word is populated.
module dcsr_readback
    import dcsr_pkg::*;
#(
    parameter bit SEQ_EN = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_en,
    input  logic [2:0]         word,
    input  logic [STAT_W-1:0]  status,
    input  logic [CTL_W-1:0]   ctl,
    input  logic [15:0]        wr_fill,
    input  logic [15:0]        rd_fill,
    input  logic [15:0]        resp_fill,
    input  logic [15:0]        wr_seq,
    input  logic [15:0]        rd_seq,
    output logic [31:0]        rdata
);
    logic [31:0] seq_word;
    logic [31:0] mux;

    // Sequence word exists only when the option is built in.
    generate
        if (SEQ_EN) begin : g_seq
            assign seq_word = {wr_seq, rd_seq};
        end else begin : g_noseq
            logic unused_seq;
            assign unused_seq = ^{wr_seq, rd_seq};
            assign seq_word   = '0;
        end
    endgenerate

    // Select the addressed word; unmapped words read zero.
    always_comb begin
        unique case (word)
            W_STATUS:  mux = {{(32-STAT_W){1'b0}}, status};
            W_CONTROL: mux = {{(32-CTL_W){1'b0}}, ctl};
            W_DFILL:   mux = {wr_fill, rd_fill};
            W_RFILL:   mux = {16'h0, resp_fill};
            W_SEQ:     mux = seq_word;
            default:   mux = '0;
        endcase
    end

    // Capture on the read strobe, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd_en)
            rdata <= mux;
    end
endmodule

// File: rtl/dma_csr_regs.sv
// Control/status register block of a descriptor-driven DMA dispatcher.
// Decodes a word-addressed 32-bit slave port, applies the auto-stop policy,
// keeps the write-1-to-clear interrupt, and sequences the software reset.
// Assumes single-cycle strobes and that bus_wr and bus_rd are not both high.
module dma_csr_regs
    import dcsr_pkg::*;
#(
    parameter bit SEQ_EN     = 1'b1,
    parameter int RST_CYCLES = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [4:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        eng_busy,
    input  logic        desc_empty,
    input  logic        desc_full,
    input  logic        resp_empty,
    input  logic        resp_full,
    input  logic [15:0] wr_fill,
    input  logic [15:0] rd_fill,
    input  logic [15:0] resp_fill,
    input  logic [15:0] wr_seq,
    input  logic [15:0] rd_seq,
    input  logic        ev_error,
    input  logic        ev_early,
    input  logic        ev_done,
    output logic        halt_issue,
    output logic        sw_rst_pulse,
    output logic        irq
);
    logic [2:0]        word;
    logic              rst_active;
    logic              wr_ctl;
    logic              swr_start;
    logic              clr_all;
    logic              st_w1c;
    logic [CTL_W-1:0]  ctl_q;
    logic              stop_err_q;
    logic              stop_early_q;
    logic              irq_pend;
    logic [STAT_W-1:0] status;
    logic              unused_bits;

    assign unused_bits = ^{bus_addr[1:0], bus_wdata[31:10], bus_wdata[8:6]};

    // Write decode; control writes are locked out during the reset window.
    assign word      = bus_addr[4:2];
    assign wr_ctl    = bus_wr && (word == W_CONTROL) && !rst_active;
    assign swr_start = wr_ctl && bus_wdata[CB_SWRST];
    assign clr_all   = swr_start || rst_active;
    assign st_w1c    = bus_wr && (word == W_STATUS) && bus_wdata[SB_IRQ];

    dcsr_reset_seq #(.RST_CYCLES(RST_CYCLES)) u_rst (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (swr_start),
        .active (rst_active)
    );

    dcsr_control u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr          (clr_all),
        .wr_en        (wr_ctl),
        .wdata        (bus_wdata[CTL_W-1:0]),
        .ev_error     (ev_error),
        .ev_early     (ev_early),
        .ctl_q        (ctl_q),
        .stop_err_q   (stop_err_q),
        .stop_early_q (stop_early_q)
    );

    dcsr_irq u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr_all),
        .set_ev (ev_done || ev_error),
        .w1c    (st_w1c),
        .pend_q (irq_pend)
    );

    // Assemble the live status word.
    always_comb begin
        status    = '0;
        status[0] = eng_busy;
        status[1] = desc_empty;
        status[2] = desc_full;
        status[3] = resp_empty;
        status[4] = resp_full;
        status[5] = ctl_q[CB_STOP] && !eng_busy;
        status[6] = rst_active;
        status[7] = stop_err_q;
        status[8] = stop_early_q;
        status[SB_IRQ] = irq_pend;
    end

    dcsr_readback #(.SEQ_EN(SEQ_EN)) u_rb (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (bus_rd),
        .word      (word),
        .status    (status),
        .ctl       (ctl_q),
        .wr_fill   (wr_fill),
        .rd_fill   (rd_fill),
        .resp_fill (resp_fill),
        .wr_seq    (wr_seq),
        .rd_seq    (rd_seq),
        .rdata     (bus_rdata)
    );

    assign halt_issue   = ctl_q[CB_HALT];
    assign sw_rst_pulse = rst_active;
    assign irq          = irq_pend && ctl_q[CB_IRQ_EN];
endmodule

// File: rtl/dcsr_checker.sv
// Property checker for dma_csr_regs, attached by bind. Observes ports and the
// control/pending state; measures the reset window length with a counter.
module dcsr_checker #(
    parameter int RST_CYCLES = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic [2:0] word,
    input logic       wd_swrst,
    input logic       ev_error,
    input logic       ev_early,
    input logic       ev_done,
    input logic [5:0] ctl_q,
    input logic       irq_pend,
    input logic       stop_err_q,
    input logic       irq,
    input logic       halt_issue,
    input logic       sw_rst_pulse,
    input logic [31:0] bus_rdata
);
    localparam int CW = $clog2(RST_CYCLES + 2);

    logic [CW-1:0] len_q;
    logic          swr_wr;

    assign swr_wr = bus_wr && (word == 3'd1) && wd_swrst;

    // Count consecutive high cycles of the reset pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            len_q <= '0;
        else if (sw_rst_pulse)
            len_q <= len_q + 1'b1;
        else
            len_q <= '0;
    end

    p_pulse_max_r12: assert property (@(posedge clk) disable iff (!rst_n)
        len_q <= CW'(RST_CYCLES));

    p_pulse_len_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_rst_pulse && len_q != '0) |-> len_q == CW'(RST_CYCLES));

    p_quiet_in_reset_r12: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst_pulse |-> (!irq && !halt_issue && ctl_q == 6'd0));

    p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_pend && ctl_q[4]));

    p_irq_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev_done || ev_error) && !sw_rst_pulse && !swr_wr) |=> irq_pend);

    p_autostop_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_error && ctl_q[2] && !sw_rst_pulse && !swr_wr) |=> (ctl_q[0] && stop_err_q));

    p_autostop_early_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_early && ctl_q[3] && !sw_rst_pulse && !swr_wr) |=> ctl_q[0]);

    p_rdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd && rst_n) |=> $stable(bus_rdata));

    p_ctl_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q[1]);
endmodule

bind dma_csr_regs dcsr_checker #(.RST_CYCLES(RST_CYCLES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .word         (bus_addr[4:2]),
    .wd_swrst     (bus_wdata[1]),
    .ev_error     (ev_error),
    .ev_early     (ev_early),
    .ev_done      (ev_done),
    .ctl_q        (ctl_q),
    .irq_pend     (irq_pend),
    .stop_err_q   (stop_err_q),
    .irq          (irq),
    .halt_issue   (halt_issue),
    .sw_rst_pulse (sw_rst_pulse),
    .bus_rdata    (bus_rdata)
);

// File: tb/tb_dma_csr_regs.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module tb_dma_csr_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        eng_busy = 1'b0;
    logic        desc_empty = 1'b1;
    logic        desc_full = 1'b0;
    logic        resp_empty = 1'b1;
    logic        resp_full = 1'b0;
    logic [15:0] wr_fill = '0;
    logic [15:0] rd_fill = '0;
    logic [15:0] resp_fill = '0;
    logic [15:0] wr_seq = '0;
    logic [15:0] rd_seq = '0;
    logic        ev_error = 1'b0;
    logic        ev_early = 1'b0;
    logic        ev_done = 1'b0;
    logic        halt_issue;
    logic        sw_rst_pulse;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dma_csr_regs dut (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic pulse_ev(input int which);
        @(negedge clk);
        if (which == 0) ev_error = 1'b1;
        else if (which == 1) ev_early = 1'b1;
        else ev_done = 1'b1;
        @(negedge clk);
        ev_error = 1'b0; ev_early = 1'b0; ev_done = 1'b0;
    endtask

    task automatic soft_reset();
        bus_write(5'h04, 32'h2);
        repeat (6) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 halt", {31'b0, halt_issue}, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);
        check("R1 pulse", {31'b0, sw_rst_pulse}, 32'h0);
        bus_read(5'h04, d); check("R1 control", d, 32'h0);
        bus_read(5'h00, d); check("R4 status idle", d, 32'h0000_000A);
    endtask

    task automatic t_status_bits();
        logic [31:0] d;
        eng_busy = 1; desc_empty = 0; desc_full = 1; resp_empty = 0; resp_full = 1;
        bus_read(5'h00, d); check("R4 status flags", d, 32'h0000_0015);
        eng_busy = 0; desc_empty = 1; desc_full = 0; resp_empty = 1; resp_full = 0;
    endtask

    task automatic t_fields();
        logic [31:0] d;
        wr_fill = 16'h1234; rd_fill = 16'hABCD; resp_fill = 16'h5A5A;
        wr_seq = 16'h0102; rd_seq = 16'h0304;
        bus_read(5'h08, d); check("R2 desc fill", d, 32'h1234_ABCD);
        bus_read(5'h0C, d); check("R2 resp fill", d, 32'h0000_5A5A);
        bus_read(5'h10, d); check("R2 seq", d, 32'h0102_0304);
        wr_seq = 16'hFFFF;
        repeat (3) @(negedge clk);
        check("R2 rdata held", bus_rdata, 32'h0102_0304);
        bus_read(5'h14, d); check("R3 unmapped 0x14", d, 32'h0);
        bus_read(5'h1C, d); check("R3 unmapped 0x1C", d, 32'h0);
    endtask

    task automatic t_control_rw();
        logic [31:0] d;
        bus_write(5'h04, 32'hFFFF_FFFD);
        check("R5 halt set", {31'b0, halt_issue}, 32'h1);
        bus_read(5'h04, d); check("R5 control rw", d, 32'h0000_003D);
        bus_write(5'h04, 32'h0);
        check("R5 halt clear", {31'b0, halt_issue}, 32'h0);
        bus_write(5'h08, 32'hFFFF_FFFF);
        bus_write(5'h18, 32'hFFFF_FFFF);
        bus_read(5'h04, d); check("R6 ro write ignored ctl", d, 32'h0);
        bus_read(5'h08, d); check("R6 ro write ignored fill", d, 32'h1234_ABCD);
    endtask

    task automatic t_irq();
        logic [31:0] d;
        bus_write(5'h04, 32'h10);
        pulse_ev(2);
        check("R8 irq raised", {31'b0, irq}, 32'h1);
        bus_write(5'h00, 32'h0000_01FF);
        bus_read(5'h00, d); check("R6 status write no effect", d, 32'h0000_020A);
        bus_write(5'h00, 32'h0000_0200);
        check("R7 w1c irq", {31'b0, irq}, 32'h0);
        bus_read(5'h00, d); check("R7 w1c status", d, 32'h0000_000A);
        // Same-cycle set and clear: set wins.
        @(negedge clk);
        bus_addr = 5'h00; bus_wdata = 32'h200; bus_wr = 1'b1; ev_done = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; ev_done = 1'b0;
        check("R7 set wins", {31'b0, irq}, 32'h1);
        bus_write(5'h04, 32'h0);
        check("R8 masked", {31'b0, irq}, 32'h0);
        bus_read(5'h00, d); check("R8 pending kept", d, 32'h0000_020A);
        bus_write(5'h00, 32'h200);
    endtask

    task automatic t_autostop_err();
        logic [31:0] d;
        bus_write(5'h04, 32'h04);
        pulse_ev(0);
        bus_read(5'h04, d); check("R9 stop set", d, 32'h0000_0005);
        bus_read(5'h00, d); check("R9 R11 status", d, 32'h0000_02AA);
        eng_busy = 1'b1;
        bus_read(5'h00, d); check("R11 busy hides stop", d, 32'h0000_028B);
        eng_busy = 1'b0;
        soft_reset();
        pulse_ev(0);
        bus_read(5'h04, d); check("R9 no policy ctl", d, 32'h0);
        bus_read(5'h00, d); check("R9 no policy status", d, 32'h0000_020A);
        soft_reset();
    endtask

    task automatic t_autostop_early();
        logic [31:0] d;
        bus_write(5'h04, 32'h08);
        pulse_ev(1);
        bus_read(5'h04, d); check("R10 stop set", d, 32'h0000_0009);
        bus_read(5'h00, d); check("R10 status", d, 32'h0000_012A);
        soft_reset();
        pulse_ev(1);
        bus_read(5'h04, d); check("R10 no policy ctl", d, 32'h0);
        bus_read(5'h00, d); check("R10 no policy status", d, 32'h0000_000A);
    endtask

    task automatic t_swreset();
        logic [31:0] d;
        int hi;
        bus_write(5'h04, 32'h3C);
        pulse_ev(0);
        bus_write(5'h04, 32'h2);
        hi = 0;
        for (int i = 0; i < 10; i++) begin
            if (sw_rst_pulse) hi++;
            @(negedge clk);
        end
        check("R12 pulse length", hi, 32'd4);
        bus_read(5'h04, d); check("R12 control cleared", d, 32'h0);
        bus_read(5'h00, d); check("R12 flags cleared", d, 32'h0000_000A);
        check("R12 irq cleared", {31'b0, irq}, 32'h0);
        bus_write(5'h04, 32'h2);
        bus_write(5'h04, 32'h20);
        bus_read(5'h00, d); check("R12 reset state bit", d, 32'h0000_004A);
        repeat (5) @(negedge clk);
        bus_read(5'h04, d); check("R12 write in window ignored", d, 32'h0);
        check("R12 halt low", {31'b0, halt_issue}, 32'h0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_status_bits();
        t_fields();
        t_control_rw();
        t_irq();
        t_autostop_err();
        t_autostop_early();
        t_swreset();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule